// File: doc/BRIEF.md
# Zero-Cross Gated Volume Attenuator

This block scales six channels of signed audio samples, one sample per channel per frame, by a gain set per channel in 1 dB steps. Each channel can also be silenced. A new setting is not applied the moment it is written. It is held as a pending value and takes effect on the first frame in which that channel's signal passes through zero. Changing gain there keeps the step small and avoids audible clicks. If the signal never crosses zero, a frame counter forces the change after a bounded wait. While a change waits, a per-channel flag stays high.

Settings are written one channel at a time: a channel index, an attenuation code and a silence bit, sent with a one-cycle write strobe. A frame strobe presents all six input samples together. The scaled samples come out one cycle later with a valid strobe. A global control, immediate mode, skips the zero-crossing wait: writes apply directly, and any change still pending is applied on the next frame.

Top module: `zc_volume_attenuator`

## Requirements
- R1: During and after reset, before any frame, `out_valid` is 0, `out_samples` is all zeros, `pending` is 0, and every channel is at 0 dB and not silenced.
- R2: `out_valid` is high in exactly the cycle after each `frame_valid` cycle. Each output is floor((x*c + 16384) / 32768), where x is the input sample and c = round(32768 * 10^(-k/20)) for attenuation code k in 0..95.
- R3: An output's magnitude never exceeds the magnitude of the input sample it was computed from.
- R4: A channel whose silence bit is 1, or whose attenuation code is 96 to 127, outputs 0.
- R5: With immediate mode low, a write raises that channel's `pending` bit in the next cycle. Until the change is applied, frames keep using the previous setting.
- R6: A pending change is applied on the first frame whose sample is zero or whose sign bit differs from that channel's previous sample. The previous sample is taken as non-negative after reset. That frame's output already uses the new setting, and `pending` falls in the next cycle.
- R7: If no crossing occurs, the change is applied on the 1023rd frame after the write.
- R8: A write to a channel that already has a change pending replaces the pending value and restarts the frame count from zero.
- R9: With immediate mode high, a write takes effect for the next frame and leaves `pending` low. Any change already pending is applied on the next frame.
- R10: When a write and a frame fall in the same cycle, that frame uses the setting in force before the write.
- R11: A write to one channel leaves the other channels' outputs and `pending` bits unchanged.
- R12: `pending` changes only in cycles that carry a frame or a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_valid | input | 1 | One-cycle strobe; `in_samples` holds a new frame |
| in_samples | input | NUM_CH*SAMPLE_W | Signed samples; channel i occupies bits [i*SAMPLE_W +: SAMPLE_W] |
| wr_en | input | 1 | One-cycle setting write strobe |
| wr_ch | input | CH_W | Channel index of the write |
| wr_atten | input | 7 | Attenuation code in dB (96 to 127 means silence) |
| wr_mute | input | 1 | Silence bit of the write |
| zc_disable | input | 1 | Immediate mode: skip the zero-crossing wait |
| out_valid | output | 1 | High in the cycle after a frame |
| out_samples | output | NUM_CH*SAMPLE_W | Scaled samples, same packing as the input |
| pending | output | NUM_CH | Per-channel flag: a written setting is waiting |

## Verification
A frame's scaled outputs and `out_valid` come out of a single register, so they are due one cycle after the frame strobe. The bench drives each frame on a falling edge and reads the outputs at the next falling edge. A write's `pending` bit follows the same one-cycle rule and is read at the falling edge after the write strobe. The timeout cases count 1022 frames and confirm the old gain still holds, then check that the 1023rd frame uses the new gain. This pins down the exact frame on which the deferred change lands, rather than just a window.

// File: rtl/zcv_pkg.sv
package zcv_pkg;

   localparam int ATT_W     = 7;
   localparam int ATT_STEPS = 96;

   typedef struct packed {
      logic             mute;
      logic [ATT_W-1:0] atten;
   } zcv_setting_t;

   // Gain of one attenuation step in fixed point with frac fraction bits.
   function automatic int coef_of(input int step, input int frac);
      real r;
      r = (2.0 ** frac) * (10.0 ** (-step / 20.0));
      return $rtoi(r + 0.5);
   endfunction

endpackage

// File: rtl/zcv_zc_detect.sv
module zcv_zc_detect #(
   parameter int SAMPLE_W = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_valid,
   input  logic [SAMPLE_W-1:0] sample,
   output logic                zc
);

   logic prev_neg_q;

   assign zc = (sample == '0) || (sample[SAMPLE_W-1] != prev_neg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_neg_q <= 1'b0;
      end else if (frame_valid) begin
         prev_neg_q <= sample[SAMPLE_W-1];
      end
   end

endmodule

// File: rtl/zcv_chan_ctrl.sv
module zcv_chan_ctrl
   import zcv_pkg::*;
#(
   parameter int TIMEOUT_FRAMES = 1023
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         frame_valid,
   input  logic         zc,
   input  logic         zc_disable,
   input  logic         wr_hit,
   input  zcv_setting_t wr_set,
   output zcv_setting_t eff_set,
   output logic         pending
);

   localparam int CNT_W = $clog2(TIMEOUT_FRAMES + 1);

   zcv_setting_t     active_q;
   zcv_setting_t     pend_q;
   logic             pend_flag_q;
   logic [CNT_W-1:0] cnt_q;
   logic             expire;
   logic             apply;

   assign expire  = (cnt_q == CNT_W'(TIMEOUT_FRAMES - 1));
   assign apply   = frame_valid && pend_flag_q && (zc || expire || zc_disable);
   assign eff_set = apply ? pend_q : active_q;
   assign pending = pend_flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q    <= '0;
         pend_q      <= '0;
         pend_flag_q <= 1'b0;
         cnt_q       <= '0;
      end else begin
         if (apply) begin
            active_q    <= pend_q;
            pend_flag_q <= 1'b0;
         end else if (frame_valid && pend_flag_q) begin
            cnt_q <= cnt_q + 1'b1;
         end
         if (wr_hit) begin
            if (zc_disable) begin
               active_q    <= wr_set;
               pend_flag_q <= 1'b0;
            end else begin
               pend_q      <= wr_set;
               pend_flag_q <= 1'b1;
               cnt_q       <= '0;
            end
         end
      end
   end

endmodule

// File: rtl/zcv_gain.sv
module zcv_gain
   import zcv_pkg::*;
#(
   parameter int SAMPLE_W      = 20,
   parameter int COEF_FRAC     = 15,
   parameter bit ROUND_NEAREST = 1'b1
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  zcv_setting_t        setting,
   output logic [SAMPLE_W-1:0] scaled
);

   localparam int COEF_W = COEF_FRAC + 1;
   localparam int PROD_W = SAMPLE_W + COEF_W + 1;

   logic [COEF_W-1:0] rom [ATT_STEPS];

   for (genvar k = 0; k < ATT_STEPS; k++) begin : g_rom
      assign rom[k] = COEF_W'(coef_of(k, COEF_FRAC));
   end

   logic              silent;
   logic [ATT_W-1:0]  idx;
   logic [COEF_W-1:0] coef;
   logic signed [PROD_W-1:0] s_ext;
   logic signed [PROD_W-1:0] c_ext;
   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] biased;

   assign silent = setting.mute || (setting.atten >= ATT_W'(ATT_STEPS));
   assign idx    = silent ? '0 : setting.atten;
   assign coef   = silent ? '0 : rom[idx];
   assign s_ext  = {{(PROD_W - SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
   assign c_ext  = {{(PROD_W - COEF_W){1'b0}}, coef};
   assign prod   = s_ext * c_ext;

   if (ROUND_NEAREST) begin : g_round
      localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (COEF_FRAC - 1);
      assign biased = prod + HALF;
   end else begin : g_trunc
      assign biased = prod;
   end

   assign scaled = SAMPLE_W'(biased >>> COEF_FRAC);

endmodule

// File: rtl/zc_volume_attenuator.sv
module zc_volume_attenuator
   import zcv_pkg::*;
#(
   parameter int NUM_CH         = 6,
   parameter int SAMPLE_W       = 20,
   parameter int COEF_FRAC      = 15,
   parameter int TIMEOUT_FRAMES = 1023,
   parameter bit ROUND_NEAREST  = 1'b1,
   localparam int CH_W          = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frame_valid,
   input  logic [NUM_CH*SAMPLE_W-1:0] in_samples,
   input  logic                       wr_en,
   input  logic [CH_W-1:0]            wr_ch,
   input  logic [zcv_pkg::ATT_W-1:0]  wr_atten,
   input  logic                       wr_mute,
   input  logic                       zc_disable,
   output logic                       out_valid,
   output logic [NUM_CH*SAMPLE_W-1:0] out_samples,
   output logic [NUM_CH-1:0]          pending
);

   if (NUM_CH < 1 || NUM_CH > 64) begin : g_bad_ch
      $error("NUM_CH must lie in 1..64");
   end
   if (SAMPLE_W < 2) begin : g_bad_w
      $error("SAMPLE_W must be at least 2");
   end
   if (COEF_FRAC < 4 || COEF_FRAC > 24) begin : g_bad_frac
      $error("COEF_FRAC must lie in 4..24");
   end
   if (TIMEOUT_FRAMES < 2) begin : g_bad_to
      $error("TIMEOUT_FRAMES must be at least 2");
   end

   zcv_setting_t wr_set;
   assign wr_set = '{mute: wr_mute, atten: wr_atten};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= frame_valid;
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [SAMPLE_W-1:0] smp;
      logic [SAMPLE_W-1:0] scaled;
      logic [SAMPLE_W-1:0] out_r;
      logic                zc;
      logic                hit;
      zcv_setting_t        eff;

      assign smp = in_samples[i*SAMPLE_W +: SAMPLE_W];
      assign hit = wr_en && (wr_ch == CH_W'(i));

      zcv_zc_detect #(.SAMPLE_W(SAMPLE_W)) u_zc (
         .clk         (clk),
         .rst_n       (rst_n),
         .frame_valid (frame_valid),
         .sample      (smp),
         .zc          (zc)
      );

      zcv_chan_ctrl #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) u_ctrl (
         .clk         (clk),
         .rst_n       (rst_n),
         .frame_valid (frame_valid),
         .zc          (zc),
         .zc_disable  (zc_disable),
         .wr_hit      (hit),
         .wr_set      (wr_set),
         .eff_set     (eff),
         .pending     (pending[i])
      );

      zcv_gain #(
         .SAMPLE_W      (SAMPLE_W),
         .COEF_FRAC     (COEF_FRAC),
         .ROUND_NEAREST (ROUND_NEAREST)
      ) u_gain (
         .sample  (smp),
         .setting (eff),
         .scaled  (scaled)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_r <= '0;
         end else if (frame_valid) begin
            out_r <= scaled;
         end
      end

      assign out_samples[i*SAMPLE_W +: SAMPLE_W] = out_r;
   end

endmodule

// File: rtl/zc_volume_attenuator_chk.sv
module zc_volume_attenuator_chk #(
   parameter int NUM_CH         = 6,
   parameter int SAMPLE_W       = 20,
   parameter int TIMEOUT_FRAMES = 1023,
   parameter int CH_W           = 3
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       frame_valid,
   input logic [NUM_CH*SAMPLE_W-1:0] in_samples,
   input logic                       wr_en,
   input logic [CH_W-1:0]            wr_ch,
   input logic                       zc_disable,
   input logic                       out_valid,
   input logic [NUM_CH*SAMPLE_W-1:0] out_samples,
   input logic [NUM_CH-1:0]          pending
);

   function automatic logic [SAMPLE_W:0] mag(input logic [SAMPLE_W-1:0] v);
      logic signed [SAMPLE_W:0] e;
      e = $signed({v[SAMPLE_W-1], v});
      return (e < 0) ? $unsigned(-e) : $unsigned(e);
   endfunction

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> out_valid);
   a_r2_valid_only_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |=> !out_valid);
   a_r12_pending_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_valid && !wr_en) |=> $stable(pending));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      int unsigned wait_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wait_cnt <= 0;
         end else if (wr_en && wr_ch == CH_W'(i)) begin
            wait_cnt <= 0;
         end else if (frame_valid && pending[i]) begin
            wait_cnt <= wait_cnt + 1;
         end
      end

      a_r3_no_gain: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (mag(out_samples[i*SAMPLE_W +: SAMPLE_W])
                        <= mag($past(in_samples[i*SAMPLE_W +: SAMPLE_W]))));
      a_r5_pending_raised: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_ch == CH_W'(i) && !zc_disable) |=> pending[i]);
      a_r7_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
         pending[i] |-> (wait_cnt < TIMEOUT_FRAMES));
      a_r9_immediate_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (zc_disable && frame_valid) |=> !pending[i]);
      a_r11_other_write: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_ch != CH_W'(i) && !pending[i]) |=> !pending[i]);
   end

endmodule

bind zc_volume_attenuator zc_volume_attenuator_chk #(
   .NUM_CH         (NUM_CH),
   .SAMPLE_W       (SAMPLE_W),
   .TIMEOUT_FRAMES (TIMEOUT_FRAMES),
   .CH_W           (CH_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_valid (frame_valid),
   .in_samples  (in_samples),
   .wr_en       (wr_en),
   .wr_ch       (wr_ch),
   .zc_disable  (zc_disable),
   .out_valid   (out_valid),
   .out_samples (out_samples),
   .pending     (pending)
);

// File: tb/zc_volume_attenuator_bench.sv
`timescale 1ns/1ps
module zc_volume_attenuator_bench;

   localparam int NCH = 6;
   localparam int SW  = 20;
   localparam int TO  = 1023;
   localparam int NV  = 12;

   localparam int V_CH  [NV] = '{0, 1, 2, 3, 4, 5, 0, 1, 2, 3, 4, 5};
   localparam int V_ATT [NV] = '{0, 1, 6, 20, 95, 96, 127, 0, 40, 3, 0, 50};
   localparam int V_MUT [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0};
   localparam int V_SMP [NV] = '{12345, 100000, -200000, 524287, -524288, 300000,
                                 -77, 5000, -1, -524288, -524288, 65535};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              frame_valid = 1'b0;
   logic [NCH*SW-1:0] in_samples = '0;
   logic              wr_en = 1'b0;
   logic [2:0]        wr_ch = '0;
   logic [6:0]        wr_atten = '0;
   logic              wr_mute = 1'b0;
   logic              zc_disable = 1'b0;
   logic              out_valid;
   logic [NCH*SW-1:0] out_samples;
   logic [NCH-1:0]    pending;

   int n_checks = 0;
   int n_fail   = 0;
   int cur [NCH];

   always #2.5 clk = ~clk;

   zc_volume_attenuator u_zc_volume_attenuator (
      .clk (clk), .rst_n (rst_n), .frame_valid (frame_valid),
      .in_samples (in_samples), .wr_en (wr_en), .wr_ch (wr_ch),
      .wr_atten (wr_atten), .wr_mute (wr_mute), .zc_disable (zc_disable),
      .out_valid (out_valid), .out_samples (out_samples), .pending (pending)
   );

   function automatic int expect_out(input int s, input int att, input int mute);
      real    r;
      longint c;
      longint p;
      if (mute != 0 || att >= 96) return 0;
      r = 32768.0 * (10.0 ** (-att / 20.0));
      c = longint'($rtoi(r + 0.5));
      p = longint'(s) * c + 64'sd16384;
      return int'(p >>> 15);
   endfunction

   function automatic int out_of(input int ch);
      logic [SW-1:0] v;
      v = out_samples[ch*SW +: SW];
      return int'($signed(v));
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pack_in();
      for (int c = 0; c < NCH; c++) in_samples[c*SW +: SW] = SW'(cur[c]);
   endtask

   task automatic frame();
      pack_in();
      frame_valid = 1'b1;
      @(negedge clk);
      frame_valid = 1'b0;
   endtask

   task automatic write(input int ch, input int att, input int mute);
      wr_en = 1'b1; wr_ch = 3'(ch); wr_atten = 7'(att); wr_mute = mute[0];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic frame_write(input int ch, input int att, input int mute);
      pack_in();
      frame_valid = 1'b1;
      wr_en = 1'b1; wr_ch = 3'(ch); wr_atten = 7'(att); wr_mute = mute[0];
      @(negedge clk);
      frame_valid = 1'b0;
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      for (int c = 0; c < NCH; c++) cur[c] = 0;
      repeat (3) @(negedge clk);
      check("R1 out_valid in reset", int'(out_valid), 0);
      check("R1 pending in reset", int'(pending), 0);
      check("R1 outputs in reset", int'(out_samples == '0), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 out_valid after reset", int'(out_valid), 0);
      for (int c = 0; c < NCH; c++) cur[c] = 1234 + c;
      frame();
      for (int c = 0; c < NCH; c++) check("R1 default 0 dB", out_of(c), 1234 + c);

      // Vector table: immediate mode, one write and one frame each.
      zc_disable = 1'b1;
      for (int v = 0; v < NV; v++) begin
         write(V_CH[v], V_ATT[v], V_MUT[v]);
         for (int c = 0; c < NCH; c++) cur[c] = V_SMP[v];
         frame();
         check("R2 out_valid after frame", int'(out_valid), 1);
         check("R2/R4 scaled value", out_of(V_CH[v]),
               expect_out(V_SMP[v], V_ATT[v], V_MUT[v]));
      end
      @(negedge clk);
      check("R2 out_valid drops", int'(out_valid), 0);

      for (int c = 0; c < NCH; c++) write(c, 0, 0);
      zc_disable = 1'b0;
      for (int c = 0; c < NCH; c++) cur[c] = 3000;
      frame();

      // R5/R6/R11: deferral until sign change
      write(1, 20, 0);
      check("R5 pending raised", int'(pending[1]), 1);
      check("R11 others not pending", int'(pending & 6'b111101), 0);
      cur[1] = 2000;
      frame();
      check("R5 old gain kept", out_of(1), 2000);
      check("R5 still pending", int'(pending[1]), 1);
      cur[1] = -800;
      frame();
      check("R6 applied on sign change", out_of(1), expect_out(-800, 20, 0));
      check("R6 pending cleared", int'(pending[1]), 0);
      check("R11 other channel untouched", out_of(0), 3000);

      // R6/R4: exact-zero sample triggers a silence change
      cur[2] = 100;
      frame();
      write(2, 0, 1);
      frame();
      check("R5 silence deferred", out_of(2), 100);
      cur[2] = 0;
      frame();
      check("R6 zero sample applies", int'(pending[2]), 0);
      cur[2] = 100;
      frame();
      check("R4 silenced output", out_of(2), 0);

      // R7: timeout on the 1023rd frame
      write(3, 6, 0);
      cur[3] = 10000;
      for (int f = 0; f < TO - 1; f++) frame();
      check("R7 pending before timeout", int'(pending[3]), 1);
      check("R7 old gain before timeout", out_of(3), 10000);
      frame();
      check("R7 applied at timeout", out_of(3), expect_out(10000, 6, 0));
      check("R7 pending cleared", int'(pending[3]), 0);

      // R8: rewrite restarts the count
      write(4, 10, 0);
      cur[4] = 7000;
      for (int f = 0; f < 600; f++) frame();
      write(4, 3, 0);
      for (int f = 0; f < TO - 1; f++) frame();
      check("R8 restarted count", int'(pending[4]), 1);
      check("R8 old gain kept", out_of(4), 7000);
      frame();
      check("R8 replaced value applied", out_of(4), expect_out(7000, 3, 0));

      // R10: write and frame in one cycle
      cur[5] = -4000;
      frame_write(5, 20, 0);
      check("R10 frame uses prior setting", out_of(5), -4000);
      check("R10 write left pending", int'(pending[5]), 1);
      frame();
      check("R10 no crossing yet", out_of(5), -4000);
      repeat (5) @(negedge clk);
      check("R12 pending holds while idle", int'(pending[5]), 1);

      // R9: immediate mode
      zc_disable = 1'b1;
      frame();
      check("R9 pending applied at next frame", out_of(5), expect_out(-4000, 20, 0));
      check("R9 pending cleared", int'(pending[5]), 0);
      write(0, 40, 0);
      check("R9 no pending in immediate mode", int'(pending[0]), 0);
      frame();
      check("R9 write effective next frame", out_of(0), expect_out(3000, 40, 0));

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule